// File: doc/BRIEF.md
# Floppy data-rate clock generator

This block derives the bit-cell timing of a floppy disk controller from two free-running reference strobes. The fast strobe ticks at 16 MHz and the slow strobe at 9.6 MHz. Both arrive as single-cycle clock enables in the system clock domain.

The host writes a 2-bit rate code through a write strobe that belongs to this register alone. Only bits [1:0] of the write data are stored. The code picks a reference and a divisor. The block then emits two enables:
- a double-rate enable, which feeds the MFM encoder;
- a bit-rate enable, which marks each full bit cell.

A new code is taken up only at the end of a full bit cell, so neither enable ever produces a shortened period. The stored code, and its bit 0 on a separate pin, are brought out for drive-side logic.

Top module: `fdc_rate_clkgen`

## Requirements
- R1: While rst_ni is low, rate_code_o is 00 and dbl_en_o and bit_en_o are 0. The divider starts from zero, so the first dbl_en_o after reset follows exactly 16 fast strobes.
- R2: A cycle with rate_we_i high loads wdata_i[1:0] into rate_code_o at that clock edge, and wdata_i[7:2] are ignored. Without rate_we_i, rate_code_o holds its value.
- R3: rate_lsb_o always equals rate_code_o[0].
- R4: In use, each code selects a reference and a divisor, counted in strobes per dbl_en_o pulse: 00 uses the fast strobe /16 (500 kbit/s), 01 the slow strobe /16 (300 kbit/s), 10 the fast strobe /32 (250 kbit/s), 11 the fast strobe /64 (125 kbit/s).
- R5: dbl_en_o is a single-cycle pulse in the cycle after the clock edge that takes the terminal strobe. Strobes of the reference not selected have no effect.
- R6: bit_en_o pulses together with every second dbl_en_o pulse. Counting restarts after reset or after a rate change, and the first pulse after either is a dbl_en_o pulse without bit_en_o.
- R7: A written code goes into use only at the edge that ends a bit cell (the edge that raises bit_en_o). The code used is the one stored before that edge, and the next cell starts with the new divisor from a cleared count.
- R8: In cycles without a selected strobe, the divider holds its count and no enable pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_fast_en_i | input | 1 | 16 MHz reference strobe |
| ref_slow_en_i | input | 1 | 9.6 MHz reference strobe |
| rate_we_i | input | 1 | Load strobe for the rate register |
| wdata_i | input | 8 | Host write data; bits [1:0] are stored |
| rate_code_o | output | 2 | Stored rate code |
| rate_lsb_o | output | 1 | Bit 0 of the stored rate code |
| bit_en_o | output | 1 | Bit-rate clock enable |
| dbl_en_o | output | 1 | Double-rate clock enable |

## Verification
The bench targets writes in the middle of a cell, two writes inside one cell, and writes landing on the committing edge. A design that switched at once would show a period mixing two divisors. A design that committed the wrong code would run the following cell at the wrong length.

Stretches with no strobes at all catch a divider that free-runs or drops its count. Runs on the slow reference with the fast strobe still toggling catch a wrong reference select. A write of 0xFE catches a register that lets the upper data bits through. The period of the first pulse after reset checks that the count starts cleared.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;
  typedef enum logic [1:0] {
    RATE_500 = 2'b00,
    RATE_300 = 2'b01,
    RATE_250 = 2'b10,
    RATE_125 = 2'b11
  } rate_e;

  localparam int unsigned NUM_RATES = 4;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/rate_ctl_reg.sv
module rate_ctl_reg
  import fdc_rate_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              commit_i,
  output rate_e             host_code_o,
  output rate_e             active_code_o
);
  rate_e host_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_q   <= RATE_500;
      active_q <= RATE_500;
    end else begin
      if (we_i)     host_q   <= rate_e'(wdata_i[1:0]);
      // commit takes the value held before this edge
      if (commit_i) active_q <= host_q;
    end
  end

  assign host_code_o   = host_q;
  assign active_code_o = active_q;
endmodule

// File: rtl/ref_select.sv
module ref_select
  import fdc_rate_pkg::*;
#(
  parameter logic [NUM_RATES-1:0] SLOW_MASK = 4'b0010
) (
  input  rate_e code_i,
  input  logic  fast_en_i,
  input  logic  slow_en_i,
  output logic  tick_o
);
  logic [NUM_RATES-1:0] tick_by_code;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_src
    if (SLOW_MASK[g]) begin : g_slow
      assign tick_by_code[g] = slow_en_i;
    end else begin : g_fast
      assign tick_by_code[g] = fast_en_i;
    end
  end

  assign tick_o = tick_by_code[code_i];
endmodule

// File: rtl/cell_divider.sv
module cell_divider
  import fdc_rate_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned DIV0  = 16,
  parameter int unsigned DIV1  = 16,
  parameter int unsigned DIV2  = 32,
  parameter int unsigned DIV3  = 64
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  rate_e code_i,
  output logic  cell_end_o,
  output logic  dbl_en_o,
  output logic  bit_en_o
);
  logic [CNT_W-1:0] cnt_q, term;
  logic             phase_q, wrap, dbl_q, bit_q;

  always_comb begin
    unique case (code_i)
      RATE_500: term = CNT_W'(DIV0 - 1);
      RATE_300: term = CNT_W'(DIV1 - 1);
      RATE_250: term = CNT_W'(DIV2 - 1);
      default:  term = CNT_W'(DIV3 - 1);
    endcase
  end

  assign wrap       = tick_i && (cnt_q == term);
  assign cell_end_o = wrap && phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      dbl_q   <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      if (wrap)        cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (wrap) phase_q <= ~phase_q;
      dbl_q <= wrap;
      bit_q <= cell_end_o;
    end
  end

  assign dbl_en_o = dbl_q;
  assign bit_en_o = bit_q;
endmodule

// File: rtl/fdc_rate_clkgen.sv
module fdc_rate_clkgen
  import fdc_rate_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DIV_500  = 16,
  parameter int unsigned DIV_300  = 16,
  parameter int unsigned DIV_250  = 32,
  parameter int unsigned DIV_125  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_fast_en_i,
  input  logic              ref_slow_en_i,
  input  logic              rate_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [1:0]        rate_code_o,
  output logic              rate_lsb_o,
  output logic              bit_en_o,
  output logic              dbl_en_o
);
  localparam int unsigned DIV_MAX = max4(DIV_500, DIV_300, DIV_250, DIV_125);
  localparam int unsigned CNT_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

  rate_e host_code, active_code;
  logic  tick, cell_end;

  rate_ctl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (rate_we_i),
    .wdata_i      (wdata_i),
    .commit_i     (cell_end),
    .host_code_o  (host_code),
    .active_code_o(active_code)
  );

  ref_select #(.SLOW_MASK(4'b0010)) u_sel (
    .code_i   (active_code),
    .fast_en_i(ref_fast_en_i),
    .slow_en_i(ref_slow_en_i),
    .tick_o   (tick)
  );

  cell_divider #(
    .CNT_W(CNT_W), .DIV0(DIV_500), .DIV1(DIV_300), .DIV2(DIV_250), .DIV3(DIV_125)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .code_i    (active_code),
    .cell_end_o(cell_end),
    .dbl_en_o  (dbl_en_o),
    .bit_en_o  (bit_en_o)
  );

  assign rate_code_o = host_code;
  assign rate_lsb_o  = host_code[0];
endmodule

// File: rtl/fdc_rate_clkgen_chk.sv
module fdc_rate_clkgen_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ref_fast_en_i,
  input logic              ref_slow_en_i,
  input logic              rate_we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [1:0]        rate_code_o,
  input logic              bit_en_o,
  input logic              dbl_en_o,
  input logic [1:0]        active_code
);
  AST_CODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_we_i |=> rate_code_o == $past(wdata_i[1:0])); // R2
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rate_we_i |=> $stable(rate_code_o)); // R2
  AST_BIT_WITH_DBL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_o |-> dbl_en_o); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbl_en_o |=> !dbl_en_o); // R5
  AST_NO_REF_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_fast_en_i && !ref_slow_en_i) |=> !dbl_en_o); // R8
  AST_SWITCH_AT_CELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_code) |-> bit_en_o); // R7
endmodule

bind fdc_rate_clkgen fdc_rate_clkgen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ref_fast_en_i(ref_fast_en_i),
  .ref_slow_en_i(ref_slow_en_i),
  .rate_we_i    (rate_we_i),
  .wdata_i      (wdata_i),
  .rate_code_o  (rate_code_o),
  .bit_en_o     (bit_en_o),
  .dbl_en_o     (dbl_en_o),
  .active_code  (active_code)
);

// File: tb/tb_fdc_rate_clkgen.sv
`timescale 1ns/1ps
module tb_fdc_rate_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_en = 1'b0, slow_en = 1'b0, we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [1:0] rate_code;
  logic       rate_lsb, bit_en, dbl_en;

  int checks = 0, fails = 0, cyc = 0;
  int smode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int  m_cnt = 0, m_phase = 0, m_active = 0, m_host = 0;
  bit  m_tick = 0, e_dbl = 0, e_bit = 0;
  int  seen = 0, last_period = 0;

  always #4 clk = ~clk;

  fdc_rate_clkgen dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_fast_en_i(fast_en), .ref_slow_en_i(slow_en),
    .rate_we_i(we), .wdata_i(wdata), .rate_code_o(rate_code), .rate_lsb_o(rate_lsb),
    .bit_en_o(bit_en), .dbl_en_o(dbl_en)
  );

  function automatic int div_of(int c);
    case (c)
      0: return 16;
      1: return 16;
      2: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // model update at the active edge, from pre-edge values
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_active = 0; m_host = 0;
      m_tick = 0; e_dbl = 0; e_bit = 0;
    end else begin
      int old_host;
      old_host = m_host;
      m_tick = (m_active == 1) ? slow_en : fast_en;
      e_dbl = m_tick && (m_cnt == div_of(m_active) - 1);
      e_bit = e_dbl && (m_phase == 1);
      if (e_dbl) begin
        if (m_phase == 1) m_active = old_host;
        m_phase = 1 - m_phase;
        m_cnt = 0;
      end else if (m_tick) m_cnt++;
      if (we) m_host = wdata[1:0];
    end
  end

  // sample away from the edge, then drive strobes
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(dbl_en == e_dbl, "R5 R7 dbl_en_o", dbl_en, e_dbl);
      check(bit_en == e_bit, "R6 bit_en_o", bit_en, e_bit);
      check(rate_code == m_host[1:0], "R2 rate_code_o", rate_code, m_host);
      check(rate_lsb == rate_code[0], "R3 rate_lsb_o", rate_lsb, rate_code[0]);
      if (m_tick) seen++;
      if (dbl_en) begin last_period = seen; seen = 0; end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (smode)
      0: begin fast_en = (cyc % 8 == 0); slow_en = (cyc % 13 == 0); end
      1: begin fast_en = lfsr[0]; slow_en = lfsr[3] & lfsr[7]; end
      default: begin fast_en = 1'b0; slow_en = 1'b0; end
    endcase
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wait_dbl(output bit was_bit);
    do @(negedge clk); while (!dbl_en);
    was_bit = bit_en;
    #1;
  endtask

  task automatic wait_commit();
    bit b;
    do wait_dbl(b); while (!b);
  endtask

  task automatic host_write(input logic [7:0] v);
    @(negedge clk); #1 we = 1'b1; wdata = v;
    @(negedge clk); #1 we = 1'b0;
    check(rate_code == v[1:0], "R2 load", rate_code, v[1:0]);
    check(rate_lsb == v[0], "R3 lsb", rate_lsb, v[0]);
  endtask

  task automatic period_check(input int exp, input string req);
    bit b;
    wait_dbl(b);
    wait_dbl(b);
    check(last_period == exp, req, last_period, exp);
  endtask

  initial begin
    bit b;
    repeat (4) @(negedge clk);
    check(rate_code == 2'b00 && !dbl_en && !bit_en, "R1 reset state",
          {rate_code, dbl_en, bit_en}, 0);
    #1 rst_n = 1'b1;
    wait_dbl(b);
    check(last_period == 16, "R1 first period", last_period, 16);
    check(!b, "R6 first pulse has no bit_en", b, 0);
    period_check(16, "R4 code 00");

    host_write(8'h01);
    wait_commit();
    period_check(16, "R4 code 01 slow ref");
    host_write(8'hFE);
    check(rate_code == 2'b10, "R2 upper bits ignored", rate_code, 2);
    wait_commit();
    period_check(32, "R4 code 10");
    host_write(8'h03);
    wait_commit();
    period_check(64, "R4 code 11");

    // R7: switch waits for the end of the cell
    wait_commit();
    host_write(8'h00);
    wait_dbl(b);
    check(last_period == 64 && !b, "R7 old divisor mid cell", last_period, 64);
    wait_dbl(b);
    check(last_period == 64 && b, "R7 old divisor up to commit", last_period, 64);
    wait_dbl(b);
    check(last_period == 16 && !b, "R7 new divisor after commit", last_period, 16);

    // R8: no strobes, count holds
    smode = 2;
    repeat (200) begin
      @(negedge clk);
      check(!dbl_en, "R8 no pulse without strobe", dbl_en, 0);
    end
    smode = 0;
    wait_dbl(b);
    check(last_period == 16, "R8 count held across gap", last_period, 16);

    // two writes in one cell: last one wins
    host_write(8'h02);
    host_write(8'h01);
    wait_commit();
    period_check(16, "R7 last write committed");

    // random strobes and writes
    smode = 1;
    for (int i = 0; i < 12; i++) begin
      repeat (150 + (lfsr % 300)) @(negedge clk);
      host_write(lfsr[9:2]);
    end
    repeat (2000) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule